// File: doc/BRIEF.md
# SPI Target Front End with Echo Response

This block is the serial front end of a register-style SPI target. A host sends fixed frames in SPI mode 0: one flag bit that says whether the access writes (1) or reads (0), a 7-bit address, one data byte and, when checking is switched on, one CRC byte. A frame that arrives whole, with a correct CRC where one is required, is handed to internal logic through a valid/ready buffer. The internal logic answers by loading a 16-bit response word into the block. That word is shifted back to the host during the host's next frame.

The host can always tell a usable answer from a failed one. If nothing was loaded since the previous frame, the host receives all ones followed by a zero CRC byte. If the previous frame failed its CRC check, the host receives all ones followed by 0xAA. All SPI pins are sampled into the block's own clock domain, so SCLK must be several times slower than the system clock.

Top module: `spi_echo_target`

## Requirements
- R1: MOSI is sampled on rising SCLK while CS is low. The first bit of a frame is the write flag (1 = write, 0 = read), the next seven bits are the address MSB first, and the next eight bits are the data byte. The handed-off word carries the flag in bit 15, the address in bits 14:8 and the data in bits 7:0. Read frames pass their data byte through unchanged.
- R2: With checking off (crc_en low when CS falls), a frame is complete after 16 bits, and any further bits before CS rises are ignored.
- R3: With checking on, the third byte is compared with a CRC-8 computed MSB first over the 16 frame bits (polynomial 0x07, start value 0x00, no final inversion). A complete frame whose CRC matches is handed off when CS rises.
- R4: A complete frame with a CRC mismatch is not handed off, and the next frame returns 0xFFFF followed by 0xAA.
- R5: If no response word was loaded since the last complete frame, the next frame returns 0xFFFF, followed by 0x00 when checking is on.
- R6: A loaded response word is returned MSB first on the next frame, followed by its CRC-8 when checking is on. MISO holds its first bit from the fall of CS and changes only after falling SCLK edges.
- R7: If CS rises before the required bit count (16, or 24 with checking on), nothing is handed off and the pending response is kept for the following frame.
- R8: in_valid stays high with in_word unchanged until in_ready is seen high. A newer accepted frame replaces a word still waiting.
- R9: A load marks the response as fresh. Every complete frame, good or bad, clears that mark. A load in the same cycle as a frame end wins.
- R10: After reset, in_valid is low and the first response is the stale pattern. MISO is low while CS is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| crc_en | input | 1 | Enables the CRC byte; sampled when CS falls |
| in_valid | output | 1 | Accepted frame waiting for internal logic |
| in_ready | input | 1 | Internal logic takes the waiting frame |
| in_word | output | 16 | Accepted frame {flag, address, data} |
| ld_en | input | 1 | Loads the response word |
| ld_word | input | 16 | Response word for the next frame |

## Verification
Every cycle, the assertions check four things: the hand-off hold rule, that a new word appears only after a good frame end and never after a bad one, that the freshness mark follows loads and frame ends, and that MISO stays still between falling SCLK edges and starts at one when the response is stale. Only the bench scenarios can show the exact bit sequences: the echoed word with its CRC, the 0xFFFF00 and 0xFFFFAA patterns, and a pending response surviving a short frame. They also show that extra bits are ignored and that the flag, address and data fields land where R1 places them.

// File: rtl/spi_echo_pkg.sv
// Shared widths, response kinds and the CRC-8 routine for the SPI echo target.
package spi_echo_pkg;

    localparam int unsigned ADDR_W  = 7;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned CRC_W   = 8;
    localparam int unsigned FRAME_W = 1 + ADDR_W + DATA_W;
    localparam int unsigned RSP_W   = FRAME_W + CRC_W;

    localparam logic [CRC_W-1:0]   CRC_POLY     = 8'h07;
    localparam logic [CRC_W-1:0]   CRC_STALE    = 8'h00;
    localparam logic [CRC_W-1:0]   CRC_FAILMARK = 8'hAA;
    localparam logic [FRAME_W-1:0] WORD_SENT    = {FRAME_W{1'b1}};

    // Which pattern the next frame sends back
    typedef enum logic [1:0] {
        RSP_STALE  = 2'd0,
        RSP_LOADED = 2'd1,
        RSP_CRCERR = 2'd2
    } rsp_kind_t;

    // Bitwise CRC, MSB first, start value zero, no final inversion
    function automatic logic [CRC_W-1:0] crc_calc(input logic [FRAME_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = FRAME_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ d[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/spi_echo_sync.sv
// Multi-bit synchronizer with edge pulses.
// Assumes each input bit is an independent level; the edge pulses are
// one clk cycle wide and arrive STAGES+1 cycles after the pin changes.
module spi_echo_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] pipe [STAGES];
    logic [WIDTH-1:0] prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop of the chain samples the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[0] <= RST_VAL;
                    else        pipe[0] <= d_in;
                end
            end else begin : g_next
                // Later flops settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[s] <= RST_VAL;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    // Delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= pipe[STAGES-1];
    end

    assign q    = pipe[STAGES-1];
    assign rise = q & ~prev;
    assign fall = ~q & prev;

endmodule

// File: rtl/spi_echo_rx.sv
// Frame receiver: shifts MOSI on rising SCLK, counts bits up to the frame
// length chosen when CS fell, and judges the frame when CS rises.
// Assumes SCLK idles low (mode 0) and that CS edges and SCLK edges do not
// land in the same synchronized cycle.
module spi_echo_rx
    import spi_echo_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_act,
    input  logic               cs_start,
    input  logic               cs_end,
    input  logic               sclk_rise,
    input  logic               mosi,
    input  logic               crc_en,
    output logic               frame_done,
    output logic               frame_bad,
    output logic               frame_good,
    output logic [FRAME_W-1:0] frame_word
);

    localparam int unsigned CNT_W = $clog2(RSP_W + 1);

    logic [RSP_W-1:0] shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] need;
    logic             crc_mode;
    logic             full;
    logic             crc_ok;

    // Frame length follows the mode latched at CS fall
    assign need = crc_mode ? CNT_W'(RSP_W) : CNT_W'(FRAME_W);
    assign full = (bit_cnt == need);

    // Capture MOSI bits until the frame length is reached
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            crc_mode <= 1'b0;
        end else if (cs_start) begin
            bit_cnt  <= '0;
            crc_mode <= crc_en;
        end else if (cs_act && sclk_rise && (bit_cnt < need)) begin
            shreg   <= {shreg[RSP_W-2:0], mosi};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Frame word sits above the CRC byte only when checking is on
    assign frame_word = crc_mode ? shreg[RSP_W-1:CRC_W] : shreg[FRAME_W-1:0];
    assign crc_ok     = (crc_calc(frame_word) == shreg[CRC_W-1:0]);

    assign frame_done = cs_end && full;
    assign frame_bad  = frame_done && crc_mode && !crc_ok;
    assign frame_good = frame_done && !frame_bad;

endmodule

// File: rtl/spi_echo_tx.sv
// Response selector and MISO shifter. Keeps the loaded word and the kind
// of answer due, builds the response word at CS fall and shifts it out on
// falling SCLK. Assumes at most one load per frame gap is meaningful.
module spi_echo_tx
    import spi_echo_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_act,
    input  logic               cs_start,
    input  logic               sclk_fall,
    input  logic               ld_en,
    input  logic [FRAME_W-1:0] ld_word,
    input  logic               frame_done,
    input  logic               frame_bad,
    output logic               miso,
    output logic               rsp_upd
);

    rsp_kind_t          kind;
    logic [FRAME_W-1:0] out_buf;
    logic [RSP_W-1:0]   rsp;
    logic [RSP_W-1:0]   shreg;

    // Track what the next frame should answer; a load beats a frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind    <= RSP_STALE;
            out_buf <= '0;
        end else if (ld_en) begin
            kind    <= RSP_LOADED;
            out_buf <= ld_word;
        end else if (frame_done) begin
            kind    <= frame_bad ? RSP_CRCERR : RSP_STALE;
        end
    end

    // Assemble the full response word for the chosen kind
    always_comb begin
        unique case (kind)
            RSP_LOADED: rsp = {out_buf, crc_calc(out_buf)};
            RSP_CRCERR: rsp = {WORD_SENT, CRC_FAILMARK};
            default:    rsp = {WORD_SENT, CRC_STALE};
        endcase
    end

    // Load at CS fall, shift after each falling SCLK edge
    always_ff @(posedge clk) begin
        if (!rst_n)                   shreg <= '0;
        else if (cs_start)            shreg <= rsp;
        else if (cs_act && sclk_fall) shreg <= {shreg[RSP_W-2:0], 1'b0};
    end

    assign miso    = cs_act & shreg[RSP_W-1];
    assign rsp_upd = (kind == RSP_LOADED);

endmodule

// File: rtl/spi_echo_target.sv
// SPI mode 0 target front end. Synchronizes the SPI pins, receives
// fixed frames, hands accepted frames to internal logic through a
// valid/ready buffer and echoes the loaded response on the next frame.
// Assumes SCLK is at least eight times slower than clk.
module spi_echo_target
    import spi_echo_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sclk,
    input  logic               spi_cs_n,
    input  logic               spi_mosi,
    output logic               spi_miso,
    input  logic               crc_en,
    output logic               in_valid,
    input  logic               in_ready,
    output logic [FRAME_W-1:0] in_word,
    input  logic               ld_en,
    input  logic [FRAME_W-1:0] ld_word
);

    localparam int unsigned PIN_N   = 3;
    localparam int unsigned P_SCLK  = 0;
    localparam int unsigned P_CS    = 1;
    localparam int unsigned P_MOSI  = 2;
    localparam logic [PIN_N-1:0] PIN_RST = 3'b010;

    logic [PIN_N-1:0]   pin_q, pin_rise, pin_fall;
    logic               cs_act, cs_start, cs_end, sclk_rise, sclk_fall;
    logic               frame_done, frame_bad, frame_good;
    logic [FRAME_W-1:0] frame_word;
    logic               rsp_upd;
    logic               unused_edges;

    spi_echo_sync #(
        .WIDTH   (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({spi_mosi, spi_cs_n, spi_sclk}),
        .q     (pin_q),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    assign cs_act       = ~pin_q[P_CS];
    assign cs_start     = pin_fall[P_CS];
    assign cs_end       = pin_rise[P_CS];
    assign sclk_rise    = pin_rise[P_SCLK];
    assign sclk_fall    = pin_fall[P_SCLK];
    assign unused_edges = pin_rise[P_MOSI] ^ pin_fall[P_MOSI];

    spi_echo_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .cs_start   (cs_start),
        .cs_end     (cs_end),
        .sclk_rise  (sclk_rise),
        .mosi       (pin_q[P_MOSI]),
        .crc_en     (crc_en),
        .frame_done (frame_done),
        .frame_bad  (frame_bad),
        .frame_good (frame_good),
        .frame_word (frame_word)
    );

    spi_echo_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .cs_start   (cs_start),
        .sclk_fall  (sclk_fall),
        .ld_en      (ld_en),
        .ld_word    (ld_word),
        .frame_done (frame_done),
        .frame_bad  (frame_bad),
        .miso       (spi_miso),
        .rsp_upd    (rsp_upd)
    );

    // Incoming buffer: newest good frame wins, ready empties it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_valid <= 1'b0;
            in_word  <= '0;
        end else if (frame_good) begin
            in_valid <= 1'b1;
            in_word  <= frame_word;
        end else if (in_ready) begin
            in_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_echo_checker.sv
// Cycle-level rules for the SPI echo target, bound into every instance.
module spi_echo_checker
    import spi_echo_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cs_act,
    input logic               cs_start,
    input logic               sclk_fall,
    input logic               frame_done,
    input logic               frame_good,
    input logic               frame_bad,
    input logic               rsp_upd,
    input logic               ld_en,
    input logic               spi_miso,
    input logic               in_valid,
    input logic               in_ready,
    input logic [FRAME_W-1:0] in_word
);

    a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_ready && !frame_good |=> in_valid && $stable(in_word));

    a_r3_new_word_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_valid) |-> $past(frame_good));

    a_r4_bad_no_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        frame_bad && !in_valid |=> !in_valid);

    a_r9_load_marks_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> rsp_upd);

    a_r9_frame_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !ld_en |=> !rsp_upd);

    a_r5_stale_starts_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_start && !rsp_upd |=> spi_miso);

    a_r6_miso_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        cs_act && !sclk_fall && !cs_start |=> !cs_act || $stable(spi_miso));

endmodule

bind spi_echo_target spi_echo_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .cs_start   (cs_start),
    .sclk_fall  (sclk_fall),
    .frame_done (frame_done),
    .frame_good (frame_good),
    .frame_bad  (frame_bad),
    .rsp_upd    (rsp_upd),
    .ld_en      (ld_en),
    .spi_miso   (spi_miso),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_word    (in_word)
);

// File: tb/spi_echo_target_bench.sv
`timescale 1ns/1ps
module spi_echo_target_bench;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        crc_en = 1'b0;
    logic        in_valid;
    logic        in_ready = 1'b0;
    logic [15:0] in_word;
    logic        ld_en = 1'b0;
    logic [15:0] ld_word = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Bench model of the response and the incoming buffer
    int          m_kind = 0;     // 0 stale, 1 loaded, 2 crc error
    logic [15:0] m_rsp_word = '0;
    bit          m_valid = 0;
    logic [15:0] m_in = '0;

    always #2.5 clk = ~clk;

    spi_echo_target u_spi_echo_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sclk (spi_sclk),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso),
        .crc_en   (crc_en),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_word  (in_word),
        .ld_en    (ld_en),
        .ld_word  (ld_word)
    );

    // Byte-at-a-time CRC-8, poly 0x07, start 0
    function automatic logic [7:0] ref_crc(input logic [15:0] w);
        logic [7:0] c = 8'h00;
        for (int b = 1; b >= 0; b--) begin
            c = c ^ w[b*8 +: 8];
            for (int k = 0; k < 8; k++)
                c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    function automatic logic [23:0] model_rsp();
        case (m_kind)
            1:       return {m_rsp_word, ref_crc(m_rsp_word)};
            2:       return 24'hFFFFAA;
            default: return 24'hFFFF00;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(input int nbits, input logic [23:0] bits,
                             output logic [23:0] got);
        got = '0;
        spi_cs_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = bits[23-i];
            tick(HALF);
            got[23-i] = spi_miso;
            spi_sclk = 1'b1;
            tick(HALF);
            spi_sclk = 1'b0;
        end
        tick(HALF);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        tick(2 * HALF);
    endtask

    task automatic do_load(input logic [15:0] w);
        ld_word = w;
        ld_en   = 1'b1;
        tick(1);
        ld_en   = 1'b0;
        m_kind = 1;
        m_rsp_word = w;
    endtask

    task automatic consume(input string req);
        in_ready = 1'b1;
        tick(1);
        in_ready = 1'b0;
        tick(1);
        m_valid = 0;
        chk(req, "in_valid after ready", in_valid, 0);
    endtask

    task automatic xfer(input string req, input bit crc, input logic [15:0] w,
                        input logic [7:0] flip, input int nbits);
        logic [23:0] bits, got, expr;
        int  need;
        bit  done, bad;
        need   = crc ? 24 : 16;
        crc_en = crc;
        bits   = crc ? {w, ref_crc(w) ^ flip} : {w, 8'($urandom)};
        expr   = model_rsp();
        run_frame(nbits, bits, got);
        chk(req, "miso response", got >> (24 - nbits), expr >> (24 - nbits));
        done = (nbits >= need);
        bad  = done && crc && (flip != 8'h00);
        if (done) m_kind = bad ? 2 : 0;
        if (done && !bad) begin
            m_valid = 1;
            m_in    = w;
        end
        chk(req, "in_valid", in_valid, m_valid);
        if (m_valid) chk(req, "in_word", in_word, m_in);
        chk("R10", "miso idle", spi_miso, 0);
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        logic [7:0]  flip;
        bit          crc;
        int          nb, r;
        void'($urandom(32'd4242));
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R10 reset state
        chk("R10", "in_valid at reset", in_valid, 0);
        chk("R10", "miso at reset", spi_miso, 0);

        // R5 stale answers, with and without CRC; R3 good CRC hand-off
        xfer("R5", 1, 16'h8123, 8'h00, 24);
        consume("R3");
        xfer("R5", 0, 16'h0456, 8'h00, 16);
        consume("R5");

        // R6 loaded echo, then R9 freshness cleared
        do_load(16'hA55A);
        xfer("R6", 1, 16'h9A01, 8'h00, 24);
        consume("R6");
        xfer("R9", 1, 16'h1234, 8'h00, 24);
        consume("R9");

        // R4 bad CRC: no hand-off, then 0xFFFFAA
        xfer("R4", 1, 16'hC0DE, 8'h10, 24);
        xfer("R4", 1, 16'h0F0F, 8'h00, 24);
        consume("R4");

        // R7 short frame keeps the pending response
        do_load(16'h3C81);
        xfer("R7", 1, 16'h7777, 8'h00, 10);
        xfer("R7", 1, 16'h5511, 8'h00, 24);
        consume("R7");

        // R8 newer frame replaces the waiting one
        xfer("R8", 0, 16'h1111, 8'h00, 16);
        xfer("R8", 0, 16'h2222, 8'h00, 16);
        chk("R8", "replaced word", in_word, 16'h2222);
        consume("R8");

        // R2 extra bits ignored with checking off
        xfer("R2", 0, 16'hBEEF, 8'h00, 24);
        consume("R2");

        // R1 field placement: write flag, address 0x5A, data 0x3C
        xfer("R1", 0, {1'b1, 7'h5A, 8'h3C}, 8'h00, 16);
        chk("R1", "flag", in_word[15], 1'b1);
        chk("R1", "address", in_word[14:8], 7'h5A);
        chk("R1", "data", in_word[7:0], 8'h3C);
        consume("R1");

        // Random mix of modes, loads, CRC errors, short and long frames
        for (int it = 0; it < 60; it++) begin
            crc  = 1'($urandom % 2);
            if ($urandom % 2 == 0) do_load(16'($urandom));
            w    = 16'($urandom);
            flip = ($urandom % 4 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
            nb   = crc ? 24 : 16;
            r    = int'($urandom % 8);
            if (r == 0)              nb = 1 + int'($urandom % 15);
            else if (r == 1 && !crc) nb = 24;
            xfer("R6", crc, w, flip, nb);
            if (m_valid) consume("R8");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule